// File: doc/BRIEF.md
# Multi-Channel Biquad Cascade Engine

This block filters several independent channels of signed fixed-point samples. Each channel runs through its own cascade of second-order IIR sections. A single start pulse makes the engine walk the channels in ascending order. For each channel it does three things:

- It copies that channel's stage records from memory into a local record file.
- It filters a window of input samples through every configured stage, using one shared multiply-accumulate unit, and writes each final output back to memory.
- It writes the updated delay states back into the records, so the next run continues where this one stopped.

All traffic goes through one 32-bit, word-addressed memory port with a valid/ready handshake. A request is presented with `mem_valid`. It completes in the cycle where `mem_ready` is also high, and read data is taken from `mem_rdata` in that same cycle. While `mem_ready` is low, the engine holds address, direction and write data unchanged and does nothing else, so back-pressure only adds cycles. The configuration inputs must stay constant while `busy` is high. Each channel must be given between 1 and `STG_MAX` stages. A window length of 0 behaves like 1.

Top module: `biquad_cascade_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_valid` are low, and `mem_valid` is only ever high while `busy` is high.
- R2: Stage s of a channel (counting from 0) occupies words 7*s to 7*s+6 of that channel's record area, with no gap between stages. The words are, in order: b0, b1, the negated a1, b2, the negated a2, state2, state1.
- R3: Each stage forms y = b0*x + state1, then state1' = b1*x + (-a1)*y + state2, then state2' = b2*x + (-a2)*y. The feedback coefficients are stored already negated, so every term is added.
- R4: Products are summed at double width. Rounding (add half an LSB, then arithmetic shift right by FRAC) and saturation to the word width happen only where y, state1' or state2' is formed.
- R5: The y of one stage is the x of the next. The y of the last stage of sample n goes to word n of the channel's output area.
- R6: A channel with window length W reads inputs 0..W-1 and writes outputs 0..W-1 in order, and touches no output word at index W or above. A window of 1 is per-sample scheduling.
- R7: After its window, a channel writes state2 and state1 of each stage back to their record slots. A second start therefore continues the filter without a break.
- R8: Channels run in order 0 to `num_ch`-1, and all of one channel's output writes come before any write of the next channel. A start pulse while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse raised after the last channel's final state write. `busy` is low from that cycle on.
- R10: When WORD_W exceeds 32, every word (input, coefficient, state, output) takes two consecutive accesses, at addresses 2*i and 2*i+1 relative to the area base. Bits 31:0 go at the lower address. The upper bits, sign-extended to 32, go at the higher address.
- R11: While `mem_valid` is high and `mem_ready` low, `mem_addr`, `mem_we` and `mem_wdata` stay stable. The results do not depend on the stall pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| num_ch | input | $clog2(CH_MAX+1) | Number of channels to process |
| stage_cnt | input | CH_MAX*$clog2(STG_MAX+1) | Stage count per channel, channel c in slice c |
| win_len | input | CH_MAX*$clog2(WIN_MAX+1) | Window length per channel |
| rec_base | input | CH_MAX*AW | Record area base address per channel |
| in_base | input | CH_MAX*AW | Input sample area base per channel |
| out_base | input | CH_MAX*AW | Output sample area base per channel |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |

## Verification
The bench builds the engine with WORD_W=40, FRAC=30, CH_MAX=3, STG_MAX=4, WIN_MAX=8 and AW=12. At WORD_W=40 every transfer takes the two-access path, and 40-bit products need wide accumulation.

The three channels use 1, 3 and 4 stages with windows of 1, 5 and 8. This covers:
- per-sample and per-block scheduling;
- the deepest cascade;
- a full-window channel;
- a single-stage channel driven into positive and then negative saturation.

Two back-to-back runs are made, the first under random `mem_ready` stalls and the second without them. Together they expose state writeback, continuation and stall independence.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int REC_WORDS = 7;
  localparam int SLOT_ST2  = 5;
  localparam int SLOT_ST1  = 6;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RDX, S_MAC, S_WRY, S_WB} seq_state_t;
endpackage

// File: rtl/bq_mac.sv
module bq_mac #(
  parameter int W    = 32,
  parameter int FRAC = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                clr,
  input  logic signed [W-1:0] pre,
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] res
);
  localparam int AW2 = 2*W + 2;
  localparam logic signed [AW2-1:0] MAXV = {{(AW2-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW2-1:0] MINV = {{(AW2-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [AW2-1:0] HALF = AW2'(1) <<< (FRAC-1);

  logic signed [AW2-1:0] acc, base, prod_x, rnd;
  logic signed [2*W-1:0] prod;

  always_comb begin
    prod   = op_a * op_b;
    prod_x = AW2'(prod);
    base   = AW2'(pre);
    base   = base <<< FRAC;
    if (!clr) base = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= base + prod_x;
  end

  // R4: round half up, then saturate to W bits
  always_comb begin
    rnd = (acc + HALF) >>> FRAC;
    if (rnd > MAXV)      res = MAXV[W-1:0];
    else if (rnd < MINV) res = MINV[W-1:0];
    else                 res = rnd[W-1:0];
  end

  a_r4_res_sign_on_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc >>> FRAC) > MAXV) |-> (res == MAXV[W-1:0]));
endmodule

// File: rtl/bq_word_port.sv
module bq_word_port #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic          ack,
  output logic [W-1:0]  rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int NP = (W > 32) ? 2 : 1;

  assign mem_valid = go;
  assign mem_we    = we;

  generate
    if (NP == 1) begin : g_single
      assign mem_addr  = addr;
      assign mem_wdata = 32'(wdata);
      assign ack       = go & mem_ready;
      assign rdata     = W'(mem_rdata);
    end else begin : g_pair
      logic        part;
      logic [31:0] lo;
      assign mem_addr  = addr + AW'(part);
      assign mem_wdata = part ? {{(64-W){wdata[W-1]}}, wdata[W-1:32]} : wdata[31:0];
      assign ack       = go & mem_ready & part;
      assign rdata     = {mem_rdata[W-33:0], lo};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          part <= 1'b0;
          lo   <= '0;
        end else if (go && mem_ready) begin
          part <= ~part;
          if (!part) lo <= mem_rdata;
        end
      end
      // R10: the upper half follows at the next address
      a_r10_pack_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mem_ready && !part) |=> (mem_valid && mem_addr == $past(mem_addr) + AW'(1)));
    end
  endgenerate

  // R11: a stalled request is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/biquad_cascade_engine.sv
module biquad_cascade_engine
  import bq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FRAC    = 30,
  parameter int CH_MAX  = 4,
  parameter int STG_MAX = 8,
  parameter int WIN_MAX = 1024,
  parameter int AW      = 16,
  localparam int CHW = $clog2(CH_MAX+1),
  localparam int SGW = $clog2(STG_MAX+1),
  localparam int WLW = $clog2(WIN_MAX+1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CHW-1:0]        num_ch,
  input  logic [CH_MAX*SGW-1:0] stage_cnt,
  input  logic [CH_MAX*WLW-1:0] win_len,
  input  logic [CH_MAX*AW-1:0]  rec_base,
  input  logic [CH_MAX*AW-1:0]  in_base,
  input  logic [CH_MAX*AW-1:0]  out_base,
  output logic                  busy,
  output logic                  done,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata
);
  localparam int NP   = (WORD_W > 32) ? 2 : 1;
  localparam int RECN = STG_MAX * REC_WORDS;
  localparam int RIW  = $clog2(RECN + 1);

  seq_state_t st;
  logic [CHW-1:0] ch;
  logic [RIW-1:0] k, rb, wb_idx, last_load, last_wb;
  logic [WLW-1:0] n;
  logic [SGW-1:0] stg, cur_stg;
  logic [WLW-1:0] cur_win;
  logic [AW-1:0]  cur_rb, cur_ib, cur_ob;
  logic [2:0]     ph;
  logic signed [WORD_W-1:0] x, ycur, pre, ma, mb, mac_res;
  logic [WORD_W-1:0] rec [RECN];
  logic mac_en, mac_clr;
  logic wp_go, wp_we, wp_ack;
  logic [AW-1:0] wp_addr;
  logic [WORD_W-1:0] wp_wdata, wp_rdata;

  assign cur_stg   = stage_cnt[ch*SGW +: SGW];
  assign cur_win   = win_len[ch*WLW +: WLW];
  assign cur_rb    = rec_base[ch*AW +: AW];
  assign cur_ib    = in_base[ch*AW +: AW];
  assign cur_ob    = out_base[ch*AW +: AW];
  assign rb        = RIW'(stg) * RIW'(REC_WORDS);
  assign wb_idx    = RIW'(k >> 1) * RIW'(REC_WORDS) + RIW'(SLOT_ST2) + RIW'(k[0]);
  assign last_load = RIW'(cur_stg) * RIW'(REC_WORDS) - 1'b1;
  assign last_wb   = RIW'(cur_stg) * RIW'(2) - 1'b1;
  assign busy      = (st != S_IDLE);

  always_comb begin
    wp_go = 1'b0; wp_we = 1'b0; wp_addr = '0; wp_wdata = '0;
    mac_en = 1'b0; mac_clr = 1'b0; pre = '0; ma = '0; mb = '0;
    case (st)
      S_LOAD: begin wp_go = 1'b1; wp_addr = cur_rb + AW'(k) * AW'(NP); end
      S_RDX:  begin wp_go = 1'b1; wp_addr = cur_ib + AW'(n) * AW'(NP); end
      S_WRY:  begin wp_go = 1'b1; wp_we = 1'b1; wp_addr = cur_ob + AW'(n) * AW'(NP); wp_wdata = ycur; end
      S_WB:   begin wp_go = 1'b1; wp_we = 1'b1; wp_addr = cur_rb + AW'(wb_idx) * AW'(NP); wp_wdata = rec[wb_idx]; end
      S_MAC: begin
        mac_en = (ph != 3'd5);
        case (ph)
          3'd0: begin mac_clr = 1'b1; pre = $signed(rec[rb+SLOT_ST1]); ma = $signed(rec[rb]);     mb = x;    end
          3'd1: begin mac_clr = 1'b1; pre = $signed(rec[rb+SLOT_ST2]); ma = $signed(rec[rb+1]);   mb = x;    end
          3'd2: begin                                                  ma = $signed(rec[rb+2]);   mb = ycur; end
          3'd3: begin mac_clr = 1'b1;                                  ma = $signed(rec[rb+3]);   mb = x;    end
          3'd4: begin                                                  ma = $signed(rec[rb+4]);   mb = ycur; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  bq_mac #(.W(WORD_W), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .clr(mac_clr),
    .pre(pre), .op_a(ma), .op_b(mb), .res(mac_res));

  bq_word_port #(.W(WORD_W), .AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n), .go(wp_go), .we(wp_we), .addr(wp_addr),
    .wdata(wp_wdata), .ack(wp_ack), .rdata(wp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (st == S_LOAD && wp_ack) rec[k] <= wp_rdata;
    if (st == S_MAC && ph == 3'd3) rec[rb+SLOT_ST1] <= mac_res;
    if (st == S_MAC && ph == 3'd5) rec[rb+SLOT_ST2] <= mac_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ch <= '0; k <= '0; n <= '0; stg <= '0; ph <= '0;
      x <= '0; ycur <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin ch <= '0; k <= '0; st <= S_LOAD; end
        S_LOAD: if (wp_ack) begin
          if (k == last_load) begin k <= '0; n <= '0; st <= S_RDX; end
          else k <= k + 1'b1;
        end
        S_RDX: if (wp_ack) begin x <= wp_rdata; stg <= '0; ph <= '0; st <= S_MAC; end
        S_MAC: begin
          if (ph == 3'd1) ycur <= mac_res;
          if (ph == 3'd5) begin
            x  <= ycur;
            ph <= '0;
            if (stg == cur_stg - 1'b1) st <= S_WRY;
            else stg <= stg + 1'b1;
          end else ph <= ph + 1'b1;
        end
        S_WRY: if (wp_ack) begin
          if (({1'b0, n} + 1'b1) >= {1'b0, cur_win}) begin k <= '0; st <= S_WB; end
          else begin n <= n + 1'b1; st <= S_RDX; end
        end
        S_WB: if (wp_ack) begin
          if (k == last_wb) begin
            k <= '0;
            if (ch == num_ch - 1'b1) begin st <= S_IDLE; done <= 1'b1; end
            else begin ch <= ch + 1'b1; st <= S_LOAD; end
          end else k <= k + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_port_idle: assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> busy);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_launch: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
endmodule

// File: tb/biquad_cascade_engine_bench.sv
module biquad_cascade_engine_bench;
  localparam int W = 40, F = 30, NC = 3, SM = 4, WM = 8, AW = 12;
  localparam int CHW = $clog2(NC+1), SGW = $clog2(SM+1), WLW = $clog2(WM+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_ready = 1'b0;
  logic busy, done, mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [NC*SGW-1:0] stage_cnt;
  logic [NC*WLW-1:0] win_len;
  logic [NC*AW-1:0] rec_base, in_base, out_base;
  logic [31:0] mem [4096];
  int checks = 0, failures = 0, done_cnt = 0, last_ch = 0, order_err = 0, rdy_pct = 100;
  int sc [NC] = '{1, 3, 4};
  int wl [NC] = '{1, 5, 8};
  logic signed [W-1:0] cf [NC][SM][7];
  logic signed [W-1:0] ex [NC][WM];

  always #5 clk = ~clk;

  biquad_cascade_engine #(.WORD_W(W), .FRAC(F), .CH_MAX(NC), .STG_MAX(SM), .WIN_MAX(WM), .AW(AW)) u_biquad_cascade_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .num_ch(CHW'(NC)), .stage_cnt(stage_cnt),
    .win_len(win_len), .rec_base(rec_base), .in_base(in_base), .out_base(out_base),
    .busy(busy), .done(done), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
    mem_ready <= ($urandom_range(99) < rdy_pct);
  end
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mem_valid && mem_ready && mem_we && mem_addr >= 12'd1024) begin
      if (int'((mem_addr - 12'd1024) >> 6) < last_ch) order_err++;
      last_ch = int'((mem_addr - 12'd1024) >> 6);
    end
  end

  function automatic int rba(int c); return c * 64; endfunction
  function automatic int iba(int c); return 512 + c * 64; endfunction
  function automatic int oba(int c); return 1024 + c * 64; endfunction

  task automatic put(int a, logic signed [W-1:0] v);
    mem[a] = v[31:0];
    mem[a+1] = {{24{v[W-1]}}, v[W-1:32]};
  endtask
  function automatic logic signed [W-1:0] get(int a);
    return {mem[a+1][7:0], mem[a]};
  endfunction

  function automatic logic signed [81:0] mul(logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [81:0] ea, eb;
    ea = a; eb = b;
    return ea * eb;
  endfunction
  function automatic logic signed [81:0] sh(logic signed [W-1:0] a);
    logic signed [81:0] e;
    e = a;
    return e <<< F;
  endfunction
  function automatic logic signed [W-1:0] rs(logic signed [81:0] a);
    logic signed [81:0] r;
    r = (a + (82'sd1 <<< (F-1))) >>> F;
    if (r > 82'sd549755813887) return 40'sh7FFFFFFFFF;
    if (r < -82'sd549755813888) return 40'sh8000000000;
    return r[W-1:0];
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3 R4 R5: reference cascade, carrying states in cf
  task automatic model();
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < wl[c]; n++) begin
        logic signed [W-1:0] xv, y, s1;
        xv = get(iba(c) + 2*n);
        for (int s = 0; s < sc[c]; s++) begin
          y  = rs(sh(cf[c][s][6]) + mul(cf[c][s][0], xv));
          s1 = rs(sh(cf[c][s][5]) + mul(cf[c][s][1], xv) + mul(cf[c][s][2], y));
          cf[c][s][5] = rs(mul(cf[c][s][3], xv) + mul(cf[c][s][4], y));
          cf[c][s][6] = s1;
          xv = y;
        end
        ex[c][n] = xv;
      end
  endtask

  task automatic fill_inputs(bit neg);
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < WM + 1; n++) begin
        put(iba(c) + 2*n, W'($signed($urandom_range(32'h3FFFFFFF)) - 32'sh20000000) <<< 6);
        mem[oba(c) + 2*n] = 32'hDEADBEEF;
        mem[oba(c) + 2*n + 1] = 32'hDEADBEEF;
      end
    put(iba(0), neg ? 40'sh8000000000 : 40'sh7FFFFFFFF0);  // saturation corner
  endtask

  task automatic run_and_check(string tag, bit poke_start);
    int cyc = 0;
    last_ch = 0; order_err = 0; done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_start && cyc == 40) start = 1'b1;
      if (poke_start && cyc == 41) start = 1'b0;
    end
    if (cyc >= 20000) begin
      failures++;
      $display("FAIL R9 watchdog: no done, actual=timeout expected=done");
    end
    chk({"R9 busy low at done ", tag}, W'(busy), '0);
    repeat (30) @(negedge clk);
    chk({"R8 start while busy ignored ", tag}, W'(done_cnt), W'(1));
    chk({"R8 still idle ", tag}, W'(busy), '0);
    chk({"R8 channel write order ", tag}, W'(order_err), '0);
    for (int c = 0; c < NC; c++) begin
      for (int n = 0; n < wl[c]; n++) chk({"R5 R3 R4 output ", tag}, get(oba(c) + 2*n), ex[c][n]);
      chk({"R10 upper word sign extension ", tag}, W'(mem[oba(c) + 2*wl[c] - 1]),
          W'({{24{ex[c][wl[c]-1][W-1]}}, ex[c][wl[c]-1][W-1:32]}));
      chk({"R6 word past window untouched ", tag}, W'(mem[oba(c) + 2*wl[c]]), W'(32'hDEADBEEF));
      for (int s = 0; s < sc[c]; s++) begin
        chk({"R7 R2 state2 slot ", tag}, get(rba(c) + 2*(7*s + 5)), cf[c][s][5]);
        chk({"R7 R2 state1 slot ", tag}, get(rba(c) + 2*(7*s + 6)), cf[c][s][6]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240));
    for (int c = 0; c < NC; c++) begin
      stage_cnt[c*SGW +: SGW] = SGW'(sc[c]);
      win_len[c*WLW +: WLW]   = WLW'(wl[c]);
      rec_base[c*AW +: AW]    = AW'(rba(c));
      in_base[c*AW +: AW]     = AW'(iba(c));
      out_base[c*AW +: AW]    = AW'(oba(c));
      for (int s = 0; s < SM; s++)
        for (int j = 0; j < 7; j++) begin
          cf[c][s][j] = W'($signed($urandom_range(32'h1FFFFFFF)) - 32'sh10000000);
          if (j == 2 || j == 4) cf[c][s][j] = cf[c][s][j] >>> 1;
        end
    end
    cf[0][0][0] = 40'sd2040109465;  // b0 about 1.9
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < SM; s++)
        for (int j = 0; j < 7; j++) put(rba(c) + 2*(7*s + j), cf[c][s][j]);
    repeat (3) @(negedge clk);
    chk("R1 reset busy", W'(busy), '0);
    chk("R1 reset done", W'(done), '0);
    chk("R1 reset mem_valid", W'(mem_valid), '0);
    rst_n = 1'b1;
    // R11: first run under random stalls
    rdy_pct = 60;
    fill_inputs(1'b0);
    model();
    chk("R4 positive saturation", ex[0][0], 40'sh7FFFFFFFFF);
    run_and_check("run1", 1'b1);
    // R7: second run continues from written-back states, no stalls
    rdy_pct = 100;
    fill_inputs(1'b1);
    model();
    chk("R4 negative saturation", ex[0][0], 40'sh8000000000);
    run_and_check("run2", 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule